// File: doc/BRIEF.md
# Unaligned Little-Endian Load Splitter

This block turns one load request (a byte address plus an access size of 1, 2, 4 or 8 bytes) into the sequence of aligned word reads that a 32-bit memory bus can serve. The bus only accepts word addresses, so the two lowest byte-address bits are never presented to it. A request that fits inside one word costs a single read. A request that crosses a word boundary, or is wider than the bus, is split into two or three reads. The reads are issued one at a time, lowest word first.

As the words return, the block keeps them in a small staging buffer. It then picks out the requested bytes starting at the byte offset of the request and places them in a 64-bit result. The lowest-addressed byte goes into the least significant lane, and every lane beyond the access size reads as zero. The load side sees a ready signal that drops while a split access is running. A one-cycle done pulse marks the cycle in which the assembled value is presented. A new request may be accepted in that same cycle.

Top module: `load_split_top`

## Requirements
- R1: While and directly after reset, `ld_ready` is 1, and `bus_req`, `ld_done` and `ld_data` are all 0.
- R2: A request is taken at a rising edge where `ld_req` and `ld_ready` are both 1. `ld_addr` is the address of the first byte. `ld_size` encodes the width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R3: In the cycle after a request is taken, `bus_req` is 1 and `bus_waddr` equals `ld_addr` shifted right by 2, which is the word holding the first byte.
- R4: The number of bus reads equals ((`ld_addr[1:0]` + bytes − 1) >> 2) + 1. An aligned access of 4 bytes or fewer uses one read, an aligned 8-byte access uses two, and an 8-byte access at offset 1, 2 or 3 uses three.
- R5: Only one read is outstanding at a time. `bus_req` stays 1 with `bus_waddr` unchanged until `bus_valid` is seen. Each following read is issued in the next cycle at the next higher word address.
- R6: The byte at address `ld_addr`+i appears in `ld_data[8i+7:8i]` (little-endian).
- R7: Bits of `ld_data` above the access width are 0.
- R8: `ld_ready` is 0 from the cycle after acceptance until the done cycle. A `ld_req` raised in that interval is ignored: it changes neither the reads issued nor the result.
- R9: `ld_done` is 1 for exactly one cycle, the cycle after the edge at which the last `bus_valid` is sampled. `ld_ready` returns to 1 in that cycle. `ld_data` holds its value until the next done.
- R10: A request presented during the done cycle is accepted at the next edge, so loads can run back-to-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Load request |
| ld_addr | input | 32 | Byte address of the first byte |
| ld_size | input | 2 | Access width code (0:1B, 1:2B, 2:4B, 3:8B) |
| ld_ready | output | 1 | Splitter idle and able to accept a request |
| ld_done | output | 1 | One-cycle pulse: result valid |
| ld_data | output | 64 | Assembled, zero-extended little-endian result |
| bus_req | output | 1 | Bus read request |
| bus_waddr | output | 30 | Word address of the read |
| bus_valid | input | 1 | Read data returned for the current request |
| bus_data | input | 32 | Returned word |

## Verification
The done pulse of one load and the acceptance of the next load can land in the same cycle. In that cycle the result register is written while a new plan is captured into the same control registers. The bench provokes this by presenting the next request at the very sample point where it first sees `ld_done`. It then judges both sides: the finished load's data must be correct at that point, and the new load must have pulled `ld_ready` low one cycle later and must issue its own first read at the right word. A second overlap, a stray request raised while reads are still in flight, is also provoked and must leave both the read sequence and the result untouched.

// File: rtl/ls_pkg.sv
package ls_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } ls_size_e;
endpackage

// File: rtl/ls_span.sv
module ls_span #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 4,
  parameter int SIZE_W    = 2,
  parameter int CNT_W     = 2
) (
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [SIZE_W-1:0]                      size,
  output logic [ADDR_W-$clog2(BUS_BYTES)-1:0]    first_waddr,
  output logic [$clog2(BUS_BYTES)-1:0]           offset,
  output logic [CNT_W-1:0]                       nreads
);
  localparam int OFF_W = $clog2(BUS_BYTES);
  localparam int SW    = 16;

  logic [SW-1:0] last_rel;

  always_comb begin
    first_waddr = addr[ADDR_W-1:OFF_W];
    offset      = addr[OFF_W-1:0];
    last_rel    = SW'(offset) + (SW'(1) << size) - SW'(1);
    nreads      = CNT_W'(last_rel >> OFF_W) + CNT_W'(1);
  end
endmodule

// File: rtl/ls_gather.sv
module ls_gather #(
  parameter int BUS_BYTES = 4,
  parameter int SLOTS     = 3,
  parameter int CNT_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         capture,
  input  logic [CNT_W-1:0]             slot,
  input  logic [BUS_BYTES*8-1:0]       word,
  output logic [SLOTS*BUS_BYTES*8-1:0] merged
);
  localparam int BW = BUS_BYTES * 8;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [BW-1:0] slot_q;
    logic          hit;
    assign hit = capture && (slot == CNT_W'(k));
    always_ff @(posedge clk) begin
      if (rst) slot_q <= '0;
      else if (hit) slot_q <= word;
    end
    assign merged[k*BW +: BW] = hit ? word : slot_q;
  end

  // R4: a captured word never targets a slot beyond the staging depth
  p_slot_range_r4: assert property (@(posedge clk) disable iff (rst)
    capture |-> (slot < CNT_W'(SLOTS)));
endmodule

// File: rtl/ls_align.sv
module ls_align #(
  parameter int BUS_BYTES = 4,
  parameter int RES_BYTES = 8,
  parameter int SLOTS     = 3,
  parameter int SIZE_W    = 2
) (
  input  logic [SLOTS*BUS_BYTES*8-1:0]  staged,
  input  logic [$clog2(BUS_BYTES)-1:0]  offset,
  input  logic [SIZE_W-1:0]             size,
  output logic [RES_BYTES*8-1:0]        result
);
  localparam int OFF_W = $clog2(BUS_BYTES);
  localparam int IDX_W = $clog2(SLOTS*BUS_BYTES);
  localparam int NB_W  = $clog2(RES_BYTES) + 1;

  logic [NB_W-1:0] nbytes;
  assign nbytes = NB_W'(1) << size;

  for (genvar i = 0; i < RES_BYTES; i++) begin : g_lane
    logic [IDX_W-1:0] src;
    logic             live;
    assign src  = IDX_W'(offset) + IDX_W'(i);
    assign live = NB_W'(i) < nbytes;
    assign result[i*8 +: 8] = live ? staged[{src, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/ls_ctrl.sv
module ls_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 4,
  parameter int RES_BYTES = 8,
  parameter int SIZE_W    = 2,
  parameter int CNT_W     = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                ld_req,
  input  logic [SIZE_W-1:0]                   ld_size,
  input  logic [ADDR_W-$clog2(BUS_BYTES)-1:0] plan_waddr,
  input  logic [$clog2(BUS_BYTES)-1:0]        plan_off,
  input  logic [CNT_W-1:0]                    plan_nreads,
  input  logic                                bus_valid,
  input  logic [RES_BYTES*8-1:0]              assembled,
  output logic                                take,
  output logic [CNT_W-1:0]                    cnt,
  output logic [$clog2(BUS_BYTES)-1:0]        off_q,
  output logic [SIZE_W-1:0]                   size_q,
  output logic                                ld_ready,
  output logic                                ld_done,
  output logic [RES_BYTES*8-1:0]              ld_data,
  output logic                                bus_req,
  output logic [ADDR_W-$clog2(BUS_BYTES)-1:0] bus_waddr
);
  import ls_pkg::*;

  localparam int OFF_W = $clog2(BUS_BYTES);
  localparam int WA_W  = ADDR_W - OFF_W;

  logic [CNT_W-1:0] nreads_q;
  logic             accept;
  logic             last;

  assign accept = ld_ready && ld_req;
  assign take   = bus_req && bus_valid;
  assign last   = take && (cnt == nreads_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_ready  <= 1'b1;
      ld_done   <= 1'b0;
      ld_data   <= '0;
      bus_req   <= 1'b0;
      bus_waddr <= '0;
      cnt       <= '0;
      nreads_q  <= '0;
      off_q     <= '0;
      size_q    <= '0;
    end else begin
      ld_done <= 1'b0;
      if (accept) begin
        ld_ready  <= 1'b0;
        bus_req   <= 1'b1;
        bus_waddr <= plan_waddr;
        off_q     <= plan_off;
        size_q    <= ld_size;
        nreads_q  <= plan_nreads;
        cnt       <= '0;
      end else if (take) begin
        if (last) begin
          bus_req  <= 1'b0;
          ld_ready <= 1'b1;
          ld_done  <= 1'b1;
          ld_data  <= assembled;
        end else begin
          cnt       <= cnt + CNT_W'(1);
          bus_waddr <= bus_waddr + WA_W'(1);
        end
      end
    end
  end

  // R8: the load side is never ready while a bus read is pending
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(ld_ready && bus_req));
  // R5: a pending read keeps its request and address until data returns
  p_hold_read_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_valid) |=> (bus_req && $stable(bus_waddr)));
  // R5: after a returned word, either the access ends or the next word follows
  p_next_word_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_valid) |=> (!bus_req || (bus_waddr == $past(bus_waddr) + WA_W'(1))));
  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    ld_done |=> !ld_done);
  // R9: ready is back when done is shown
  p_done_ready_r9: assert property (@(posedge clk) disable iff (rst)
    ld_done |-> ld_ready);
  // R4: the read index stays below the planned read count
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (cnt < nreads_q));
  // R7: a single-byte result carries nothing above its low lane
  p_zero_ext_r7: assert property (@(posedge clk) disable iff (rst)
    (ld_done && (size_q == SZ_BYTE)) |-> (ld_data[RES_BYTES*8-1:8] == '0));
endmodule

// File: rtl/load_split_top.sv
module load_split_top #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 4,
  parameter int RES_BYTES = 8,
  localparam int OFF_W    = $clog2(BUS_BYTES),
  localparam int WA_W     = ADDR_W - OFF_W,
  localparam int SIZE_W   = $clog2($clog2(RES_BYTES) + 1),
  localparam int SLOTS    = (BUS_BYTES - 1 + RES_BYTES - 1) / BUS_BYTES + 1,
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_req,
  input  logic [ADDR_W-1:0]      ld_addr,
  input  logic [SIZE_W-1:0]      ld_size,
  output logic                   ld_ready,
  output logic                   ld_done,
  output logic [RES_BYTES*8-1:0] ld_data,
  output logic                   bus_req,
  output logic [WA_W-1:0]        bus_waddr,
  input  logic                   bus_valid,
  input  logic [BUS_BYTES*8-1:0] bus_data
);
  logic [WA_W-1:0]              plan_waddr;
  logic [OFF_W-1:0]             plan_off;
  logic [CNT_W-1:0]             plan_nreads;
  logic                         take;
  logic [CNT_W-1:0]             cnt;
  logic [OFF_W-1:0]             off_q;
  logic [SIZE_W-1:0]            size_q;
  logic [SLOTS*BUS_BYTES*8-1:0] merged;
  logic [RES_BYTES*8-1:0]       assembled;

  ls_span #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_span (
    .addr(ld_addr), .size(ld_size),
    .first_waddr(plan_waddr), .offset(plan_off), .nreads(plan_nreads)
  );

  ls_gather #(.BUS_BYTES(BUS_BYTES), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_gather (
    .clk(clk), .rst(rst), .capture(take), .slot(cnt), .word(bus_data), .merged(merged)
  );

  ls_align #(.BUS_BYTES(BUS_BYTES), .RES_BYTES(RES_BYTES), .SLOTS(SLOTS), .SIZE_W(SIZE_W)) u_align (
    .staged(merged), .offset(off_q), .size(size_q), .result(assembled)
  );

  ls_ctrl #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .RES_BYTES(RES_BYTES),
            .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .ld_req(ld_req), .ld_size(ld_size),
    .plan_waddr(plan_waddr), .plan_off(plan_off), .plan_nreads(plan_nreads),
    .bus_valid(bus_valid), .assembled(assembled),
    .take(take), .cnt(cnt), .off_q(off_q), .size_q(size_q),
    .ld_ready(ld_ready), .ld_done(ld_done), .ld_data(ld_data),
    .bus_req(bus_req), .bus_waddr(bus_waddr)
  );
endmodule

// File: tb/test_load_split_top.sv
module test_load_split_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_req;
  logic [31:0] ld_addr;
  logic [1:0]  ld_size;
  logic        ld_ready;
  logic        ld_done;
  logic [63:0] ld_data;
  logic        bus_req;
  logic [29:0] bus_waddr;
  logic        bus_valid;
  logic [31:0] bus_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lat = 0;
  int wait_cnt = 0;
  int reads = 0;
  int order_err = 0;
  int last_valid_cyc = 0;
  logic [29:0] first_w;
  logic [29:0] prev_w;
  logic [63:0] last_exp = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  load_split_top i_load_split_top (
    .clk(clk), .rst(rst), .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_ready(ld_ready), .ld_done(ld_done), .ld_data(ld_data),
    .bus_req(bus_req), .bus_waddr(bus_waddr), .bus_valid(bus_valid), .bus_data(bus_data)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] * 8'd29 + a[15:8] + 8'h5A;
  endfunction

  function automatic logic [31:0] mem_word(input logic [29:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = mem_byte({w, 2'b00} + 32'(b));
    return r;
  endfunction

  // bus responder: answers a pending read after lat idle cycles
  initial begin
    bus_valid = 1'b0;
    bus_data  = '0;
    forever begin
      @(negedge clk);
      if (bus_valid) begin
        bus_valid = 1'b0;
        wait_cnt  = 0;
      end else if (bus_req && !rst) begin
        if (wait_cnt >= lat) begin
          bus_valid = 1'b1;
          bus_data  = mem_word(bus_waddr);
          if (reads == 0) first_w = bus_waddr;
          else if (bus_waddr != prev_w + 30'd1) order_err++;
          prev_w = bus_waddr;
          reads++;
          last_valid_cyc = cyc;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // One load; caller is at a negedge. Ends at the negedge where done is seen.
  task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input int l, input logic poke);
    int nb = 1 << sz;
    logic [63:0] exp = '0;
    int exp_reads;
    int guard = 0;
    for (int i = 0; i < nb; i++) exp[i*8 +: 8] = mem_byte(a + 32'(i));
    exp_reads = int'((a + 32'(nb - 1)) >> 2) - int'(a >> 2) + 1;
    lat = l; reads = 0; order_err = 0;
    ld_addr = a; ld_size = sz; ld_req = 1'b1;
    @(negedge clk);
    if (poke) begin ld_addr = ~a; ld_size = 2'd3; ld_req = 1'b1; end
    else ld_req = 1'b0;
    check(ld_ready == 1'b0, "R8 ready low after accept", 64'(ld_ready), 64'd0);
    check(ld_done == 1'b0, "R9 done single cycle", 64'(ld_done), 64'd0);
    check(bus_req == 1'b1 && bus_waddr == a[31:2], "R3 first read word", 64'(bus_waddr), 64'(a[31:2]));
    while (!ld_done && guard < 200) begin @(negedge clk); guard++; end
    ld_req = 1'b0;
    check(ld_data == exp, "R6 R7 assembled data", ld_data, exp);
    check(reads == exp_reads, "R4 read count", 64'(reads), 64'(exp_reads));
    check(first_w == a[31:2], "R3 first word", 64'(first_w), 64'(a[31:2]));
    check(order_err == 0, "R5 increasing word order", 64'(order_err), 64'd0);
    check(cyc == last_valid_cyc + 1, "R9 done timing", 64'(cyc), 64'(last_valid_cyc + 1));
    check(ld_ready == 1'b1, "R9 ready with done", 64'(ld_ready), 64'd1);
    last_exp = exp;
  endtask

  task automatic t_reset();
    check(ld_ready == 1'b1 && bus_req == 1'b0 && ld_done == 1'b0 && ld_data == '0,
          "R1 reset state", {ld_ready, bus_req, ld_done, 61'(ld_data != '0)}, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_aligned_single();  // R4: aligned <=4 bytes, one read
    do_load(32'h0000_1000, 2'd2, 0, 1'b0);
    do_load(32'h0000_1006, 2'd1, 2, 1'b0);
    do_load(32'h0000_1003, 2'd0, 1, 1'b0);
  endtask

  task automatic t_straddle();        // R4 R6: 4 bytes at offset 1
    do_load(32'h0000_2001, 2'd2, 1, 1'b0);
    do_load(32'h0000_2003, 2'd1, 0, 1'b0);
  endtask

  task automatic t_wide_aligned();    // R4: aligned 8 bytes, two reads
    do_load(32'h0000_3008, 2'd3, 3, 1'b0);
  endtask

  task automatic t_three_words();     // R4: unaligned 8 bytes, three reads
    do_load(32'h0000_4003, 2'd3, 0, 1'b0);
    do_load(32'h0000_40F1, 2'd3, 2, 1'b0);
  endtask

  task automatic t_sweep();           // R2 R6 R7 across every size and offset
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        do_load(32'h0001_2340 + 32'(o) + 32'(s * 16), 2'(s), (s + o) % 3, 1'b0);
  endtask

  task automatic t_busy_ignore();     // R8: request while busy changes nothing
    do_load(32'h0000_5002, 2'd3, 2, 1'b1);
    do_load(32'h0000_5101, 2'd2, 1, 1'b1);
  endtask

  task automatic t_back_to_back();    // R10: next load presented in the done cycle
    do_load(32'h0000_6005, 2'd3, 0, 1'b0);
    do_load(32'h0000_6102, 2'd2, 0, 1'b0);
    do_load(32'h0000_6207, 2'd0, 0, 1'b0);
  endtask

  task automatic t_hold();            // R9: result held while idle
    repeat (4) @(negedge clk);
    check(ld_data == last_exp, "R9 data held", ld_data, last_exp);
    check(bus_req == 1'b0 && ld_done == 1'b0, "R9 idle quiet", {62'd0, bus_req, ld_done}, 64'd0);
  endtask

  initial begin
    rst = 1'b1; ld_req = 1'b0; ld_addr = '0; ld_size = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_aligned_single();
    t_straddle();
    t_wide_aligned();
    t_three_words();
    t_sweep();
    t_busy_ignore();
    t_back_to_back();
    t_hold();
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end
endmodule